// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable pipelined synchronous SRAM. It accepts a new read or write on every enabled clock edge, in any order, with no idle cycles between them. The address and control are registered on the rising edge. The write data for an operation arrives on the same pipeline position where the read data for an operation would leave. Because of this, a write can follow a read, or a read can follow a write, on the next edge with no gap and no bus turnaround. Separate input and output data ports stand in for a shared tri-state bus.

The word is two 9-bit byte lanes. The array depth is set by the address width parameter. A load cycle can start a four-beat burst that later advance cycles continue without a new address. The burst order is interleaved or linear, chosen by a pin.

The data path has no back-pressure. `rvalid` qualifies `rdata` for exactly one cycle and has no ready. The consumer must take the word in that cycle. The only way to hold the pipeline is the clock-enable pin, which freezes every stage.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded at an enabled edge E puts the stored word on `rdata` with `rvalid` high after the second enabled edge that follows E. Lane A is bits 8:0 and lane B is bits 17:9.
- R2: For a write loaded at edge E, `wdata` is sampled at the second enabled edge after E and is stored at that address.
- R3: Reads and writes may be issued on consecutive enabled edges in any mix. A read issued on the edge right after a write to the same address returns the newly written data.
- R4: `bw_n[0]` low enables lane A (bits 8:0) and `bw_n[1]` low enables lane B (bits 17:9) of a write. A lane whose bit is high keeps its old contents.
- R5: In a read cycle (`we_n` high at load) the `bw_n` inputs have no effect and nothing is stored.
- R6: A load cycle selects the block only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination is a deselect: nothing is written, `rvalid` is low after the second enabled edge, and `rdata` keeps its last value.
- R7: While `cke_n` is high, a clock edge is ignored. `rdata` and `rvalid` hold, no write happens, and no stage advances, so latencies count only enabled edges.
- R8: With `adv_ld_n` high, the block repeats the last loaded operation at the next burst address. Chip enables and `we_n` are ignored, and `bw_n` is taken fresh on each beat. The address bits above bit 1 stay fixed. Beat k (k=0..3, wrapping to 0 after 3) uses low bits `base ^ k` when `burst_lin`=0 (sampled at load), or `(base + k) mod 4` when `burst_lin`=1.
- R9: An advance cycle after a deselect load remains a deselect.
- R10: While `rst_n` is low, and after it is released, `rvalid` is 0 and `rdata` is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and output register |
| cke_n | input | 1 | Active-low clock enable; high freezes the whole block |
| sel1_n | input | 1 | Active-low chip select, sampled at load |
| sel2 | input | 1 | Active-high chip select, sampled at load |
| sel3_n | input | 1 | Active-low chip select, sampled at load |
| we_n | input | 1 | Active-low write enable, sampled at load |
| adv_ld_n | input | 1 | Low loads a new operation, high advances the burst |
| burst_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| bw_n | input | NL (2) | Active-low lane write enables, sampled every enabled edge |
| addr | input | AW (8) | Word address, sampled at load |
| wdata | input | NL*LW (18) | Write data, taken two enabled edges after its operation |
| rdata | output | NL*LW (18) | Registered read data |
| rvalid | output | 1 | High for one enabled cycle when `rdata` carries a read result |

## Verification
Every result is due at a fixed number of enabled edges after its cause. A read's data and its valid flag change after the second enabled edge that follows the read's load. A write consumes `wdata` at that same second edge, and a deselect drops `rvalid` at the same point. A stall edge shifts all of these by one. The bench drives one cycle at a time and keeps its own two-entry operation pipeline, which it shifts only on edges where `cke_n` was low. It supplies write data from that pipeline's oldest entry. One time unit after every edge it compares `rdata` and `rvalid` with the value its reference memory predicts for the entry that just left.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  // Operation carried down the pipeline
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of burst beat 'step' from a loaded base
  function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                              input logic [1:0] step,
                                              input logic       lin);
    return lin ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
// First pipeline stage: chip-select decode, load/advance and burst addressing.
module zbt_cmd_stage
  import zbt_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          we_n,
  input  logic          adv_ld_n,
  input  logic          burst_lin,
  input  logic [NL-1:0] bw_n,
  input  logic [AW-1:0] addr,
  output op_e           a_op,
  output logic [AW-1:0] a_addr,
  output logic [NL-1:0] a_bw_n
);

  // Burst context kept between beats
  op_e           brst_op;
  logic [AW-1:0] brst_base;
  logic [1:0]    brst_step;
  logic          brst_lin;

  op_e           n_op;
  logic [AW-1:0] n_base;
  logic [1:0]    n_step;
  logic          n_lin;
  logic [AW-1:0] n_addr;
  logic          selected;

  assign selected = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (!adv_ld_n) begin
      n_op   = !selected ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
      n_base = addr;
      n_step = 2'd0;
      n_lin  = burst_lin;
    end else begin
      n_op   = brst_op;
      n_base = brst_base;
      n_step = brst_step + 2'd1;
      n_lin  = brst_lin;
    end
    n_addr = {n_base[AW-1:2], burst_offset(n_base[1:0], n_step, n_lin)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brst_op   <= OP_IDLE;
      brst_base <= '0;
      brst_step <= '0;
      brst_lin  <= 1'b0;
      a_op      <= OP_IDLE;
      a_addr    <= '0;
      a_bw_n    <= '1;
    end else if (en) begin
      brst_op   <= n_op;
      brst_base <= n_base;
      brst_step <= n_step;
      brst_lin  <= n_lin;
      a_op      <= n_op;
      a_addr    <= n_addr;
      a_bw_n    <= bw_n;
    end
  end

endmodule

// File: rtl/zbt_pipe_reg.sv
// Middle stage: holds the operation one more enabled edge so write data
// lines up with the read-data slot.
module zbt_pipe_reg
  import zbt_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  op_e           in_op,
  input  logic [AW-1:0] in_addr,
  input  logic [NL-1:0] in_bw_n,
  output op_e           out_op,
  output logic [AW-1:0] out_addr,
  output logic [NL-1:0] out_bw_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_op   <= OP_IDLE;
      out_addr <= '0;
      out_bw_n <= '1;
    end else if (en) begin
      out_op   <= in_op;
      out_addr <= in_addr;
      out_bw_n <= in_bw_n;
    end
  end

endmodule

// File: rtl/zbt_lane_array.sv
// Storage array, one independently written memory per byte lane.
module zbt_lane_array #(
  parameter int AW = 8,
  parameter int NL = 2,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic [NL-1:0]    lane_we,
  input  logic [AW-1:0]    addr,
  input  logic [NL*LW-1:0] wdata,
  output logic [NL*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = mem[addr];
  end

endmodule

// File: rtl/zbt_sram.sv
// Pipelined SRAM with equal read and write latency (no turnaround cycles).
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 2,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             we_n,
  input  logic             adv_ld_n,
  input  logic             burst_lin,
  input  logic [NL-1:0]    bw_n,
  input  logic [AW-1:0]    addr,
  input  logic [NL*LW-1:0] wdata,
  output logic [NL*LW-1:0] rdata,
  output logic             rvalid
);

  localparam int DW = NL * LW;

  logic          en;
  op_e           a_op;
  logic [AW-1:0] a_addr;
  logic [NL-1:0] a_bw_n;
  op_e           b_op;
  logic [AW-1:0] b_addr;
  logic [NL-1:0] b_bw_n;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] arr_rd;

  assign en = !cke_n;

  zbt_cmd_stage #(.AW(AW), .NL(NL)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .we_n      (we_n),
    .adv_ld_n  (adv_ld_n),
    .burst_lin (burst_lin),
    .bw_n      (bw_n),
    .addr      (addr),
    .a_op      (a_op),
    .a_addr    (a_addr),
    .a_bw_n    (a_bw_n)
  );

  zbt_pipe_reg #(.AW(AW), .NL(NL)) u_mid (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .in_op    (a_op),
    .in_addr  (a_addr),
    .in_bw_n  (a_bw_n),
    .out_op   (b_op),
    .out_addr (b_addr),
    .out_bw_n (b_bw_n)
  );

  // Write commits at the data slot, with wdata sampled on this edge
  assign lane_we = (en && b_op == OP_WRITE) ? ~b_bw_n : '0;

  zbt_lane_array #(.AW(AW), .NL(NL), .LW(LW)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .addr    (b_addr),
    .wdata   (wdata),
    .rdata   (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (en) begin
      rvalid <= (b_op == OP_READ);
      if (b_op == OP_READ) rdata <= arr_rd;
    end
  end

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
  import zbt_sram_pkg::*;
#(
  parameter int NL = 2,
  parameter int LW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke_n,
  input logic             sel1_n,
  input logic             sel2,
  input logic             sel3_n,
  input logic             adv_ld_n,
  input logic [NL*LW-1:0] rdata,
  input logic             rvalid,
  input op_e              a_op,
  input op_e              b_op
);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rdata) && $stable(rvalid)));

  assert_read_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && b_op == OP_READ) |=> rvalid);

  assert_nonread_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && b_op != OP_READ) |=> !rvalid);

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld_n && !(!sel1_n && sel2 && !sel3_n)) |=> (a_op == OP_IDLE));

  assert_adv_keeps_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld_n && a_op == OP_IDLE) |=> (a_op == OP_IDLE));

endmodule

bind zbt_sram zbt_sram_chk #(.NL(NL), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke_n    (cke_n),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .adv_ld_n (adv_ld_n),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .a_op     (a_op),
  .b_op     (b_op)
);

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

  localparam int AW = 4;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          sel1_n = 1'b1;
  logic          sel2 = 1'b0;
  logic          sel3_n = 1'b1;
  logic          we_n = 1'b1;
  logic          adv_ld_n = 1'b0;
  logic          burst_lin = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #4 clk = ~clk;

  zbt_sram #(.AW(AW), .NL(NL), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .we_n(we_n), .adv_ld_n(adv_ld_n), .burst_lin(burst_lin),
    .bw_n(bw_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model
  logic [DW-1:0] refm [DEPTH];
  bit            p_v [2];
  bit            p_wr [2];
  logic [AW-1:0] p_a [2];
  logic [NL-1:0] p_bw [2];
  logic [DW-1:0] p_wd [2];
  string         p_req [2];
  bit            bs_v;
  bit            bs_wr;
  logic [AW-1:0] bs_base;
  logic [1:0]    bs_step;
  bit            bs_lin;
  bit            exp_v;
  logic [DW-1:0] exp_d;
  string         exp_req;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 18'h0B3D + salt * 18'h1C5) ^ 18'h2C71);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock cycle with raw pin values
  task automatic step(input bit c_n, input bit s1, input bit s2, input bit s3,
                      input bit w_n, input logic [1:0] b, input bit adv,
                      input bit lin, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input string req);
    logic [1:0] lo;
    cke_n = c_n; sel1_n = s1; sel2 = s2; sel3_n = s3; we_n = w_n;
    bw_n = b; adv_ld_n = adv; burst_lin = lin; addr = a;
    wdata = (!c_n && p_v[1] && p_wr[1]) ? p_wd[1] : 18'h15A5A;
    @(posedge clk);
    if (!c_n) begin
      exp_req = req;
      if (p_v[1] && p_wr[1]) begin
        for (int l = 0; l < NL; l++)
          if (!p_bw[1][l]) refm[p_a[1]][l*LW +: LW] = p_wd[1][l*LW +: LW];
        exp_v = 0;
        exp_req = p_req[1];
      end else if (p_v[1]) begin
        exp_v = 1;
        exp_d = refm[p_a[1]];
        exp_req = p_req[1];
      end else begin
        exp_v = 0;
      end
      p_v[1] = p_v[0]; p_wr[1] = p_wr[0]; p_a[1] = p_a[0];
      p_bw[1] = p_bw[0]; p_wd[1] = p_wd[0]; p_req[1] = p_req[0];
      if (!adv) begin
        bs_v = !s1 && s2 && !s3; bs_wr = !w_n; bs_base = a;
        bs_step = 2'd0; bs_lin = lin;
      end else begin
        bs_step = bs_step + 2'd1;
      end
      lo = bs_lin ? bs_base[1:0] + bs_step : bs_base[1:0] ^ bs_step;
      p_v[0] = bs_v; p_wr[0] = bs_wr; p_a[0] = {bs_base[AW-1:2], lo};
      p_bw[0] = b; p_wd[0] = wd; p_req[0] = req;
    end else begin
      exp_req = req;
    end
    #1;
    check(rvalid === exp_v, exp_req, "rvalid", {17'd0, rvalid}, {17'd0, exp_v});
    check(rdata === exp_d, exp_req, "rdata", rdata, exp_d);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [1:0] b,
                    input string r);
    step(0, 0, 1, 0, 0, b, 0, 0, AW'(a), d, r);
  endtask
  task automatic rd(input int a, input logic [1:0] b, input string r);
    step(0, 0, 1, 0, 1, b, 0, 0, AW'(a), 18'h0, r);
  endtask
  task automatic nop(input string r);
    step(0, 1, 0, 1, 1, 2'b11, 0, 0, '0, 18'h0, r);
  endtask
  task automatic stall(input string r);
    step(1, 0, 1, 0, 0, 2'b00, 0, 1, 4'hF, 18'h3FFFF, r);
  endtask
  task automatic adv(input logic [DW-1:0] d, input logic [1:0] b, input string r);
    step(0, 1, 0, 1, 1, b, 1, 1, 4'h0, d, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin p_v[i] = 0; p_req[i] = "R10"; end
    bs_v = 0; bs_wr = 0; bs_base = '0; bs_step = '0; bs_lin = 0;
    exp_v = 0; exp_d = '0; exp_req = "R10";
    for (int i = 0; i < DEPTH; i++) refm[i] = '0;

    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check(rvalid === 1'b0, "R10", "rvalid in reset", {17'd0, rvalid}, 18'd0);
    check(rdata === '0, "R10", "rdata in reset", rdata, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    nop("R10"); nop("R10");

    // R2, R1: fill every word then read it back
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0), 2'b00, "R2");
    for (int a = 0; a < DEPTH; a++) rd(a, 2'b11, "R1");
    nop("R1"); nop("R1");

    // R3: alternating write/read on consecutive edges
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, pat(a, 1), 2'b00, "R3");
      rd(a, 2'b11, "R3");
      rd((a + 5) % DEPTH, 2'b11, "R3");
      wr((a + 3) % DEPTH, pat(a, 2), 2'b00, "R3");
    end
    nop("R3"); nop("R3");

    // R4: every lane-enable pattern
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        wr(a, pat(a, 10 + b), 2'(b), "R4");
        rd(a, 2'b11, "R4");
      end
    nop("R4"); nop("R4");

    // R5: reads with lane enables asserted store nothing
    for (int a = 4; a < 8; a++) rd(a, 2'b00, "R5");
    for (int a = 4; a < 8; a++) rd(a, 2'b11, "R5");
    nop("R5"); nop("R5");

    // R6: all chip-enable combinations attempt a write
    for (int c = 0; c < 8; c++) begin
      step(0, c[0], c[1], c[2], 0, 2'b00, 0, 0, 4'd9, pat(c, 20), "R6");
      step(0, c[0], c[1], c[2], 1, 2'b00, 0, 0, 4'd9, 18'h0, "R6");
      rd(9, 2'b11, "R6");
    end
    nop("R6"); nop("R6"); nop("R6");

    // R7: stalls threaded through the pipeline
    wr(10, pat(10, 30), 2'b00, "R7");
    stall("R7");
    rd(10, 2'b11, "R7");
    stall("R7"); stall("R7");
    wr(11, pat(11, 31), 2'b00, "R7");
    stall("R7");
    rd(11, 2'b11, "R7");
    stall("R7");
    nop("R7"); stall("R7"); stall("R7"); nop("R7"); nop("R7");

    // R8: write and read bursts, both orders, every start offset, with wrap
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        step(0, 0, 1, 0, 0, 2'b00, 0, 1'(lin), AW'(4 + s), pat(s, 40 + lin), "R8");
        for (int k = 1; k < 5; k++) adv(pat(s + k, 50 + lin), 2'(k % 2 ? 0 : 1), "R8");
        step(0, 0, 1, 0, 1, 2'b00, 0, 1'(lin), AW'(4 + ((s + 1) % 4)), 18'h0, "R8");
        for (int k = 1; k < 5; k++) adv(18'h0, 2'b00, "R8");
        stall("R8");
        adv(18'h0, 2'b00, "R8");
      end
    nop("R8"); nop("R8");

    // R9: advance after deselect stays idle
    nop("R9");
    for (int k = 0; k < 3; k++) step(0, 0, 1, 0, 0, 2'b00, 1, 0, 4'd12, pat(k, 60), "R9");
    for (int a = 12; a < 16; a++) rd(a, 2'b11, "R9");
    nop("R9"); nop("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule